// File: doc/BRIEF.md
# SIMD Lane Element Walker

This block turns a vector held in ordinary scalar registers, each cut into narrower SIMD lanes, into a flat series of element positions. On a start request it samples a 3-bit element-width code, a base register number and a vector length counted in whole registers. It then reports how many elements that vector really holds, which is the register count times the number of lanes per register.

After that it walks the element indices in ascending order, one per accepted cycle. For each index it gives the physical register that holds the element and the lowest and highest bit of the element's lane inside that register. A downstream consumer pulls elements with a ready signal. A done pulse closes a walk, and an error pulse replaces the walk when the code cannot be used.

The lane count is always a power of two. Splitting an index into a register offset and a lane number therefore takes only a shift and a mask. No divider is used.

Top module: `simd_lane_walker`

The controller has four states:
- `ST_IDLE`: waits for `start_i`.
- `ST_WALK`: presents elements.
- `ST_FINISH`: one-cycle done pulse.
- `ST_FAULT`: one-cycle error pulse.

It has these transitions:
- IDLE→FAULT on start with an unusable code.
- IDLE→FINISH on start with a zero length.
- IDLE→WALK on any other start.
- WALK→FINISH when the last element is accepted.
- FINISH→IDLE and FAULT→IDLE unconditionally.

## Requirements
- R1: After reset the block is idle. `busy_o`, `elem_valid_o`, `done_o` and `err_o` are 0 and `eff_len_o` is 0.
- R2: Width codes: 0 means one element of XLEN bits per register. Codes 1, 2, 3, 4 and 5 mean 8, 16, 32, 64 and 128-bit elements. Codes 6 and 7 are reserved.
- R3: From the cycle after an accepted start, `eff_len_o` equals `reg_len_i × (XLEN / width)` and holds until the next accepted start.
- R4: For element index i, `phys_reg_o` = (base + floor(i / lanes)) mod 2^REG_W, where lanes = XLEN / width.
- R5: `lo_bit_o` = (i mod lanes) × width.
- R6: `hi_bit_o` = `lo_bit_o` + width − 1.
- R7: Elements appear with indices 0 to eff_len−1 in order. The first appears in the cycle after start, and a new one appears every cycle that `ready_i` was high on the previous edge.
- R8: While `elem_valid_o` is high and `ready_i` is low, the same element stays on the outputs on the next cycle.
- R9: A reserved code, or an element wider than XLEN, gives a one-cycle `err_o` pulse in the cycle after start, with `eff_len_o` = 0, no elements and no `done_o`.
- R10: `done_o` is a one-cycle pulse in the cycle after the last element is accepted.
- R11: A zero register length with a valid code gives `done_o` in the cycle after start, with no elements and `eff_len_o` = 0.
- R12: `start_i` is ignored while `busy_o` is high. The running walk, its sequence and `eff_len_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk; sampled only when idle |
| ew_code_i | input | 3 | Element-width code |
| base_reg_i | input | REG_W | First physical register of the vector |
| reg_len_i | input | VL_W | Vector length in whole registers |
| ready_i | input | 1 | Consumer accepts the presented element |
| busy_o | output | 1 | Block not idle |
| eff_len_o | output | VL_W+log2(XLEN/8) | Effective element count |
| elem_valid_o | output | 1 | An element position is presented |
| elem_idx_o | output | VL_W+log2(XLEN/8) | Index of the presented element |
| phys_reg_o | output | REG_W | Physical register of the element |
| lo_bit_o | output | log2(XLEN) | Lowest bit of the element's lane |
| hi_bit_o | output | log2(XLEN) | Highest bit of the element's lane |
| done_o | output | 1 | Walk finished (pulse) |
| err_o | output | 1 | Unusable width code (pulse) |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a stalled walk. It has to carry a different configuration, and the bench must still confirm that nothing about the running walk moved. The bench holds `ready_i` low on a repeating pattern and pulses `start_i` with another code and length while an element is being held. It then checks the full index, register and bit sequence and the reported length to the end of the walk. Register-number wraparound is reached by placing the base register near the top of the register space with byte lanes.

// File: rtl/simd_walk_pkg.sv
package simd_walk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2,
        ST_FAULT  = 2'd3
    } walk_state_e;

    localparam int LOG_W = 8;

endpackage

// File: rtl/ew_decoder.sv
module ew_decoder
    import simd_walk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]       code_i,
    output logic             ok_o,
    output logic [LOG_W-1:0] lanes_log_o,
    output logic [LOG_W-1:0] wlog_o
);
    localparam int XB_LOG = $clog2(XLEN / 8);
    localparam int XB_LOG_BITS = $clog2(XLEN);
    localparam logic [LOG_W-1:0] XB_LOG_L = LOG_W'(XB_LOG);
    localparam logic [LOG_W-1:0] XLOG_L   = LOG_W'(XB_LOG_BITS);

    logic [LOG_W-1:0] byte_log;

    always_comb begin
        byte_log    = LOG_W'(code_i) - LOG_W'(1);
        ok_o        = 1'b0;
        lanes_log_o = '0;
        wlog_o      = '0;
        unique case (code_i)
            3'd0: begin
                ok_o        = 1'b1;
                lanes_log_o = '0;
                wlog_o      = XLOG_L;
            end
            3'd1, 3'd2, 3'd3, 3'd4, 3'd5: begin
                if (byte_log <= XB_LOG_L) begin
                    ok_o        = 1'b1;
                    lanes_log_o = XB_LOG_L - byte_log;
                    wlog_o      = byte_log + LOG_W'(3);
                end
            end
            default: begin
                ok_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_locator.sv
module lane_locator
    import simd_walk_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 5,
    parameter int IDX_W = 11
) (
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [REG_W-1:0]          base_i,
    input  logic [LOG_W-1:0]          lanes_log_i,
    input  logic [LOG_W-1:0]          wlog_i,
    output logic [REG_W-1:0]          preg_o,
    output logic [$clog2(XLEN)-1:0]   lo_o,
    output logic [$clog2(XLEN)-1:0]   hi_o
);
    localparam int BIT_W = $clog2(XLEN);

    logic [IDX_W-1:0] reg_off;
    logic [IDX_W-1:0] lane_mask;
    logic [IDX_W-1:0] lane;
    logic [BIT_W:0]   span;

    always_comb begin
        reg_off   = idx_i >> lanes_log_i;
        lane_mask = (IDX_W'(1) << lanes_log_i) - IDX_W'(1);
        lane      = idx_i & lane_mask;
        preg_o    = base_i + REG_W'(reg_off);
        lo_o      = BIT_W'(lane) << wlog_i;
        span      = ((BIT_W + 1)'(1) << wlog_i) - (BIT_W + 1)'(1);
        hi_o      = lo_o + BIT_W'(span);
    end

endmodule

// File: rtl/simd_lane_walker.sv
module simd_lane_walker
    import simd_walk_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int REG_W = 5,
    parameter int VL_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [2:0]                          ew_code_i,
    input  logic [REG_W-1:0]                    base_reg_i,
    input  logic [VL_W-1:0]                     reg_len_i,
    input  logic                                ready_i,
    output logic                                busy_o,
    output logic [VL_W+$clog2(XLEN/8)-1:0]      eff_len_o,
    output logic                                elem_valid_o,
    output logic [VL_W+$clog2(XLEN/8)-1:0]      elem_idx_o,
    output logic [REG_W-1:0]                    phys_reg_o,
    output logic [$clog2(XLEN)-1:0]             lo_bit_o,
    output logic [$clog2(XLEN)-1:0]             hi_bit_o,
    output logic                                done_o,
    output logic                                err_o
);
    localparam int XB_LOG = $clog2(XLEN / 8);
    localparam int EFF_W  = VL_W + XB_LOG;
    localparam int BIT_W  = $clog2(XLEN);

    walk_state_e      state_q, state_nx;
    logic             dec_ok;
    logic [LOG_W-1:0] dec_lanes_log, dec_wlog;
    logic [LOG_W-1:0] lanes_log_q, wlog_q;
    logic [REG_W-1:0] base_q;
    logic [EFF_W-1:0] eff_len_q, idx_q;
    logic             accept, last_elem, step;

    ew_decoder #(.XLEN(XLEN)) u_dec (
        .code_i      (ew_code_i),
        .ok_o        (dec_ok),
        .lanes_log_o (dec_lanes_log),
        .wlog_o      (dec_wlog)
    );

    lane_locator #(.XLEN(XLEN), .REG_W(REG_W), .IDX_W(EFF_W)) u_loc (
        .idx_i       (idx_q),
        .base_i      (base_q),
        .lanes_log_i (lanes_log_q),
        .wlog_i      (wlog_q),
        .preg_o      (phys_reg_o),
        .lo_o        (lo_bit_o),
        .hi_o        (hi_bit_o)
    );

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_elem = (idx_q == eff_len_q - EFF_W'(1));
    assign step      = (state_q == ST_WALK) && ready_i;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!dec_ok)                state_nx = ST_FAULT;
                    else if (reg_len_i == '0)   state_nx = ST_FINISH;
                    else                        state_nx = ST_WALK;
                end
            end
            ST_WALK: begin
                if (ready_i && last_elem)       state_nx = ST_FINISH;
            end
            ST_FINISH: state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // configuration and index registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_log_q <= '0;
            wlog_q      <= '0;
            base_q      <= '0;
            eff_len_q   <= '0;
            idx_q       <= '0;
        end else if (accept) begin
            lanes_log_q <= dec_lanes_log;
            wlog_q      <= dec_wlog;
            base_q      <= base_reg_i;
            eff_len_q   <= dec_ok ? (EFF_W'(reg_len_i) << dec_lanes_log) : '0;
            idx_q       <= '0;
        end else if (step && !last_elem) begin
            idx_q       <= idx_q + EFF_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        elem_valid_o = (state_q == ST_WALK);
        done_o       = (state_q == ST_FINISH);
        err_o        = (state_q == ST_FAULT);
        eff_len_o    = eff_len_q;
        elem_idx_o   = idx_q;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && !ready_i) |=> (elem_valid_o && $stable(elem_idx_o) && $stable(phys_reg_o) && $stable(lo_bit_o))); // R8
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && ready_i && (elem_idx_o != eff_len_o - EFF_W'(1))) |=> (elem_valid_o && (elem_idx_o == EFF_W'($past(elem_idx_o) + EFF_W'(1))))); // R7
    AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && ready_i && (elem_idx_o == eff_len_o - EFF_W'(1))) |=> done_o); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (eff_len_o == '0)); // R9
    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid_o |-> (hi_bit_o >= lo_bit_o)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(eff_len_o)); // R12

endmodule

// File: tb/simd_lane_walker_bench.sv
module simd_lane_walker_bench;
    localparam int XLEN  = 64;
    localparam int REG_W = 5;
    localparam int VL_W  = 8;
    localparam int EFF_W = VL_W + 3;
    localparam int BIT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] ew_code_i = '0;
    logic [REG_W-1:0] base_reg_i = '0;
    logic [VL_W-1:0] reg_len_i = '0;
    logic ready_i = 1'b0;
    logic busy_o, elem_valid_o, done_o, err_o;
    logic [EFF_W-1:0] eff_len_o, elem_idx_o;
    logic [REG_W-1:0] phys_reg_o;
    logic [BIT_W-1:0] lo_bit_o, hi_bit_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    simd_lane_walker #(.XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W)) u_simd_lane_walker (
        .clk, .rst_n, .start_i, .ew_code_i, .base_reg_i, .reg_len_i, .ready_i,
        .busy_o, .eff_len_o, .elem_valid_o, .elem_idx_o, .phys_reg_o,
        .lo_bit_o, .hi_bit_o, .done_o, .err_o
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input int code);
        return (code == 0) ? XLEN : (8 << (code - 1));
    endfunction

    task automatic t_reset();
        check(!busy_o && !elem_valid_o && !done_o && !err_o, "R1", "idle flags",
              {busy_o, elem_valid_o, done_o, err_o}, 0);
        check(eff_len_o == 0, "R1", "eff_len", eff_len_o, 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R10 R12
    task automatic t_walk(input int code, input int base, input int len,
                          input bit stall, input bit inject);
        int w, lanes, exp_n, got, cyc, stall_idx;
        bit stalled, rdy, seen_done;
        w = width_of(code);
        lanes = XLEN / w;
        exp_n = len * lanes;
        @(negedge clk);
        ew_code_i = 3'(code); base_reg_i = REG_W'(base); reg_len_i = VL_W'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(eff_len_o == EFF_W'(exp_n), "R3", "effective length", eff_len_o, exp_n);
        got = 0; cyc = 0; stalled = 0; stall_idx = 0; seen_done = 0;
        while (!seen_done && cyc < 3000) begin
            if (done_o) begin
                seen_done = 1;
                check(got == exp_n, "R10", "elements before done", got, exp_n);
            end else begin
                rdy = stall ? ((cyc % 3) != 0) : 1'b1;
                ready_i = rdy;
                if (inject && cyc == 3) begin
                    ew_code_i = 3'd1; reg_len_i = 8'd7; base_reg_i = 5'd9; start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                if (elem_valid_o) begin
                    if (stalled)
                        check(elem_idx_o == EFF_W'(stall_idx), "R8", "held index", elem_idx_o, stall_idx);
                    if (rdy) begin
                        check(elem_idx_o == EFF_W'(got), "R7", "index order", elem_idx_o, got);
                        check(phys_reg_o == REG_W'((base + got / lanes) % 32), "R4", "register",
                              phys_reg_o, (base + got / lanes) % 32);
                        check(lo_bit_o == BIT_W'((got % lanes) * w), "R5", "low bit",
                              lo_bit_o, (got % lanes) * w);
                        check(hi_bit_o == BIT_W'((got % lanes) * w + w - 1), "R6", "high bit",
                              hi_bit_o, (got % lanes) * w + w - 1);
                        got++;
                        stalled = 0;
                    end else begin
                        stalled = 1;
                        stall_idx = int'(elem_idx_o);
                    end
                end else begin
                    check(1'b0, "R7", "element missing while walking", 0, 1);
                end
                @(negedge clk);
                cyc++;
            end
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        check(seen_done, "R10", "done seen", seen_done, 1);
        check(eff_len_o == EFF_W'(exp_n), "R12", "length after walk", eff_len_o, exp_n);
        @(negedge clk);
        check(!done_o && !busy_o, "R10", "done single pulse", {done_o, busy_o}, 0);
    endtask

    task automatic t_fault(input int code);
        @(negedge clk);
        ew_code_i = 3'(code); base_reg_i = 5'd2; reg_len_i = 8'd3; start_i = 1'b1; ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o && !elem_valid_o && !done_o, "R9", "error pulse",
              {err_o, elem_valid_o, done_o}, 4);
        check(eff_len_o == 0, "R9", "error length", eff_len_o, 0);
        @(negedge clk);
        check(!err_o && !elem_valid_o && !done_o && !busy_o, "R9", "after error",
              {err_o, elem_valid_o, done_o, busy_o}, 0);
        ready_i = 1'b0;
    endtask

    task automatic t_zero(input int code);
        @(negedge clk);
        ew_code_i = 3'(code); base_reg_i = 5'd4; reg_len_i = 8'd0; start_i = 1'b1; ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && !elem_valid_o && !err_o, "R11", "immediate done",
              {done_o, elem_valid_o, err_o}, 4);
        check(eff_len_o == 0, "R11", "zero length", eff_len_o, 0);
        @(negedge clk);
        check(!done_o && !busy_o, "R11", "after done", {done_o, busy_o}, 0);
        ready_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk(0, 3, 4, 1'b0, 1'b0);   // full-width elements
        t_walk(1, 30, 3, 1'b0, 1'b0);  // byte lanes, register wrap
        t_walk(2, 7, 2, 1'b1, 1'b0);   // half lanes with stalls
        t_walk(3, 0, 5, 1'b0, 1'b0);   // word lanes
        t_walk(4, 11, 3, 1'b1, 1'b0);  // 64-bit lanes = XLEN
        t_walk(3, 20, 2, 1'b1, 1'b1);  // start during stalled walk
        t_fault(5);                    // 128-bit wider than XLEN
        t_fault(6);
        t_fault(7);
        t_zero(1);
        t_zero(0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule